// File: doc/BRIEF.md
# Cable Port Status and Enable Controller

This block keeps track of whether each of a node's cable ports has a live partner on the far end, and from that derives the enables for each port's line transmitter, line receiver and termination bias source. A port counts as connected when the remote end's bias voltage is seen on its receive pair. The block receives this as one raw digital detect bit per port. The analog comparators, drivers and bias source are outside the block. Only their detect inputs and enable outputs appear here.

A new connection is accepted only after its detect bit has stayed high without a break for a programmable number of system clock cycles. When a port is accepted as connected, the block raises a one-cycle bus-reset request for that port. Losing a connection is never delayed. A global "no cable active" flag is taken straight from the raw detect bits, so that power management can rely on it even while the rest of the block is powered down. Each enable has its own set of blocking conditions, built from power-down, the transceiver reset input, the port's own connection status and per-port transmit and receive inhibit requests.

Top module: `cport_status_ctrl`

## Requirements
- R1: `cna_all` is 1 exactly when every bit of `bias_det` is 0. It follows `bias_det` in the same cycle without debounce, and it keeps working while `pd` is 1.
- R2: `port_conn[i]` becomes 1 only after `bias_det[i]` has been 1 at `DEB_CYCLES` consecutive rising clock edges. With `bias_det[i]` set just after an edge, `port_conn[i]` rises just after the `DEB_CYCLES`-th following edge. Any cycle with `bias_det[i]` at 0 restarts the count from zero.
- R3: When `bias_det[i]` falls, `port_conn[i]` and `tx_en[i]` / `rx_en[i]` go to 0 in the same cycle, with no clock edge needed. A later reconnect needs a full new debounce.
- R4: `bus_rst_req[i]` is 1 for exactly one cycle, and that cycle is the first cycle in which `port_conn[i]` is 1 after a debounced connect.
- R5: `tx_en[i]` is 1 only when all of these hold: `pd` is 0, `xcvr_rst_n` is 1, `port_conn[i]` is 1 and `tx_inhibit[i]` is 0.
- R6: `rx_en[i]` is 1 only when all of these hold: `pd` is 0, `port_conn[i]` is 1 and `rx_inhibit[i]` is 0. `xcvr_rst_n` has no effect on it.
- R7: `bias_en[i]` is 1 exactly when `pd` is 0 and `xcvr_rst_n` is 1. It does not depend on connection status or the inhibits.
- R8: While `pd` is 1, `port_conn`, `tx_en`, `rx_en`, `bias_en` and `bus_rst_req` are all 0, and no debounce progress is kept. After `pd` returns to 0, a port whose detect bit is high needs a full `DEB_CYCLES` count and then issues its bus-reset request.
- R9: `rst_n` is a synchronous active-low reset. At the first edge with `rst_n` at 0, every port's connection status and pending request are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset of the status logic |
| pd | input | 1 | Power-down request, active high |
| xcvr_rst_n | input | 1 | Transceiver reset condition, active low |
| bias_det | input | NPORTS | Raw remote-bias detect per port, already synchronised to `clk` |
| tx_inhibit | input | NPORTS | Internal transmit-disable request per port |
| rx_inhibit | input | NPORTS | Internal receive-disable request per port |
| port_conn | output | NPORTS | Debounced connection status per port |
| bus_rst_req | output | NPORTS | One-cycle bus-reset request per port on a debounced connect |
| tx_en | output | NPORTS | Transmitter enable per port |
| rx_en | output | NPORTS | Receiver enable per port |
| bias_en | output | NPORTS | Bias generator enable per port |
| cna_all | output | 1 | High when no port sees a remote bias (undebounced) |

## Verification
Some properties are checked by assertions on every cycle. A bus-reset request never lasts two cycles and only appears at the start of a connection. A connection is only accepted once the counter has reached its end. A dropped detect bit clears the stored status. The global inactive flag never coincides with a connected port. A transmitter is never enabled without its bias source. Power-down silences every enable. Other behaviour can only be shown by the bench's scenarios. These include the exact cycle at which a debounced connect appears, the restart after a short dropout, and the same-cycle reaction to a disconnect. They also include the fact that the transceiver reset leaves receivers alone, and the full re-debounce after power-down.

// File: rtl/cport_pkg.sv
// Package: cport_pkg
// Shared types of the cable port status controller.
// Assumes nothing beyond a synchronous clock domain.
package cport_pkg;

    // Enables produced for one cable port.
    typedef struct packed {
        logic tx;
        logic rx;
        logic bias;
    } port_en_t;

endpackage

// File: rtl/cport_debounce.sv
// Module: cport_debounce
// Asymmetric debounce for one port's remote-bias detect bit. A rise is
// accepted only after DEB_CYCLES consecutive high samples. A fall is passed
// through combinationally and clears the stored state at the next edge.
// Assumes raw_det is already synchronous to clk. Power-down discards all
// progress.
module cport_debounce #(
    parameter int DEB_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd,
    input  logic raw_det,
    output logic conn,
    output logic conn_rise
);

    localparam int CW = $clog2(DEB_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          conn_q;
    logic          rise_q;

    // Count consecutive high samples; latch the connection at the end of the count.
    always_ff @(posedge clk) begin
        if (!rst_n || pd || !raw_det) begin
            cnt_q  <= '0;
            conn_q <= 1'b0;
            rise_q <= 1'b0;
        end else begin
            rise_q <= 1'b0;
            if (!conn_q) begin
                if (cnt_q == LAST) begin
                    conn_q <= 1'b1;
                    rise_q <= 1'b1;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // A disconnect or power-down masks the stored state immediately.
    always_comb begin
        conn      = conn_q & raw_det & ~pd;
        conn_rise = rise_q & conn;
    end

    // R4: the request never stretches over two cycles.
    p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conn_rise |=> !conn_rise);

    // R4: the request marks the first connected cycle.
    p_rise_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conn_rise |-> !$past(conn));

    // R2: a connection is only taken at the end of the count.
    p_full_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conn_q) |-> ($past(cnt_q) == LAST && $past(raw_det)));

    // R3: a low sample leaves no stored connection behind.
    p_drop_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_det |=> !conn_q);

endmodule

// File: rtl/cport_enable.sv
// Module: cport_enable
// Combines the block-level conditions and one port's status into that
// port's transmitter, receiver and bias enables. Purely combinational.
module cport_enable
    import cport_pkg::*;
(
    input  logic     pd,
    input  logic     xcvr_rst_n,
    input  logic     conn,
    input  logic     tx_inhibit,
    input  logic     rx_inhibit,
    output port_en_t en
);

    // Each enable has its own blocking set; reset does not block the receiver.
    always_comb begin
        en.bias = ~pd & xcvr_rst_n;
        en.tx   = ~pd & xcvr_rst_n & conn & ~tx_inhibit;
        en.rx   = ~pd & conn & ~rx_inhibit;
    end

endmodule

// File: rtl/cport_status_ctrl.sv
// Module: cport_status_ctrl
// Top of the cable port status controller. Builds one debounce and one
// enable stage per port and derives the global no-cable flag from the raw
// detect bits. Assumes all inputs are synchronous to clk.
module cport_status_ctrl
    import cport_pkg::*;
#(
    parameter int NPORTS     = 3,
    parameter int DEB_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd,
    input  logic              xcvr_rst_n,
    input  logic [NPORTS-1:0] bias_det,
    input  logic [NPORTS-1:0] tx_inhibit,
    input  logic [NPORTS-1:0] rx_inhibit,
    output logic [NPORTS-1:0] port_conn,
    output logic [NPORTS-1:0] bus_rst_req,
    output logic [NPORTS-1:0] tx_en,
    output logic [NPORTS-1:0] rx_en,
    output logic [NPORTS-1:0] bias_en,
    output logic              cna_all
);

    port_en_t en [NPORTS];

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        cport_debounce #(
            .DEB_CYCLES(DEB_CYCLES)
        ) i_deb (
            .clk      (clk),
            .rst_n    (rst_n),
            .pd       (pd),
            .raw_det  (bias_det[p]),
            .conn     (port_conn[p]),
            .conn_rise(bus_rst_req[p])
        );

        cport_enable i_en (
            .pd        (pd),
            .xcvr_rst_n(xcvr_rst_n),
            .conn      (port_conn[p]),
            .tx_inhibit(tx_inhibit[p]),
            .rx_inhibit(rx_inhibit[p]),
            .en        (en[p])
        );

        // Unpack the per-port enable bundle onto the output vectors.
        always_comb begin
            tx_en[p]   = en[p].tx;
            rx_en[p]   = en[p].rx;
            bias_en[p] = en[p].bias;
        end
    end

    // The global flag uses the raw detects so it survives power-down.
    always_comb cna_all = ~|bias_det;

    // R1: the global flag never coexists with a connected port.
    p_cna_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cna_all |-> (port_conn == '0));

    // R7: no transmitter runs without its bias source.
    p_tx_has_bias_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en & ~bias_en) == '0);

    // R8: power-down silences every enable and request.
    p_pd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pd |-> ((tx_en | rx_en | bias_en | bus_rst_req) == '0));

    // R5: a transmitting port is a connected port.
    p_tx_needs_conn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en & ~port_conn) == '0);

endmodule

// File: tb/test_cport_status_ctrl.sv
`timescale 1ns/100ps
module test_cport_status_ctrl;

    localparam int N   = 3;
    localparam int DEB = 8;

    logic         clk = 1'b0;
    logic         rst_n, pd, xcvr_rst_n;
    logic [N-1:0] bias_det, tx_inhibit, rx_inhibit;
    logic [N-1:0] port_conn, bus_rst_req, tx_en, rx_en, bias_en;
    logic         cna_all;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    cport_status_ctrl #(.NPORTS(N), .DEB_CYCLES(DEB)) i_cport_status_ctrl (
        .clk(clk), .rst_n(rst_n), .pd(pd), .xcvr_rst_n(xcvr_rst_n),
        .bias_det(bias_det), .tx_inhibit(tx_inhibit), .rx_inhibit(rx_inhibit),
        .port_conn(port_conn), .bus_rst_req(bus_rst_req), .tx_en(tx_en),
        .rx_en(rx_en), .bias_en(bias_en), .cna_all(cna_all)
    );

    // Vector fields: {xcvr_rst_n, tx_inhibit, rx_inhibit, exp tx, exp rx, exp bias}
    localparam logic [15:0] VEC [0:7] = '{
        {1'b1, 3'b000, 3'b000, 3'b111, 3'b111, 3'b111},
        {1'b0, 3'b000, 3'b000, 3'b000, 3'b111, 3'b000},
        {1'b1, 3'b101, 3'b000, 3'b010, 3'b111, 3'b111},
        {1'b1, 3'b000, 3'b011, 3'b111, 3'b100, 3'b111},
        {1'b0, 3'b010, 3'b110, 3'b000, 3'b001, 3'b000},
        {1'b1, 3'b111, 3'b111, 3'b000, 3'b000, 3'b111},
        {1'b1, 3'b001, 3'b100, 3'b110, 3'b011, 3'b111},
        {1'b0, 3'b111, 3'b000, 3'b000, 3'b111, 3'b000}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance one edge and land 1 ns after it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic connect_all();
        bias_det = 3'b111;
        for (int k = 1; k < DEB; k++) step();
        step();
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; pd = 0; xcvr_rst_n = 1;
        bias_det = '0; tx_inhibit = '0; rx_inhibit = '0;
        step(); step();
        // R9 reset state and R1 with no cable
        chk(port_conn == 0 && bus_rst_req == 0, "R9", {port_conn, bus_rst_req}, 0);
        chk(cna_all == 1, "R1", cna_all, 1);
        chk(tx_en == 0 && rx_en == 0 && bias_en == 3'b111, "R7",
            {tx_en, rx_en, bias_en}, 9'b000000111);
        rst_n = 1;
        step();

        // R2 and R4: single-port debounce timing
        bias_det = 3'b001;
        #0.5 chk(cna_all == 0, "R1", cna_all, 0);
        for (int k = 1; k < DEB; k++) begin
            step();
            chk(port_conn[0] == 0, "R2", port_conn, 0);
        end
        step();
        chk(port_conn == 3'b001 && bus_rst_req == 3'b001, "R2_R4",
            {port_conn, bus_rst_req}, 6'b001001);
        step();
        chk(port_conn == 3'b001 && bus_rst_req == 0, "R4",
            {port_conn, bus_rst_req}, 6'b001000);

        // R2 restart after a short dropout on port 1
        bias_det[1] = 1;
        for (int k = 0; k < 5; k++) step();
        bias_det[1] = 0;
        step();
        bias_det[1] = 1;
        for (int k = 1; k < DEB; k++) step();
        chk(port_conn[1] == 0, "R2", port_conn, 3'b001);
        step();
        chk(port_conn[1] == 1 && bus_rst_req == 3'b010, "R2",
            {port_conn, bus_rst_req}, 6'b011010);

        // R3 immediate disconnect
        bias_det[0] = 0;
        #0.5;
        chk(port_conn == 3'b010 && tx_en == 3'b010 && rx_en == 3'b010, "R3",
            {port_conn, tx_en, rx_en}, 9'b010010010);
        chk(cna_all == 0, "R1", cna_all, 0);
        step();
        bias_det[0] = 1;
        step();
        chk(port_conn[0] == 0, "R3", port_conn, 3'b010);
        bias_det = 0;
        #0.5 chk(cna_all == 1 && port_conn == 0, "R1", {cna_all, port_conn}, 4'b1000);
        step();

        // Vector table over enables with all ports connected (R5 R6 R7)
        connect_all();
        chk(port_conn == 3'b111 && bus_rst_req == 3'b111, "R4",
            {port_conn, bus_rst_req}, 6'b111111);
        for (int v = 0; v < 8; v++) begin
            xcvr_rst_n = VEC[v][15];
            tx_inhibit = VEC[v][14:12];
            rx_inhibit = VEC[v][11:9];
            step();
            chk(tx_en == VEC[v][8:6], "R5", tx_en, VEC[v][8:6]);
            chk(rx_en == VEC[v][5:3], "R6", rx_en, VEC[v][5:3]);
            chk(bias_en == VEC[v][2:0], "R7", bias_en, VEC[v][2:0]);
        end
        xcvr_rst_n = 1; tx_inhibit = 0; rx_inhibit = 0;

        // R8 power-down
        pd = 1;
        #0.5;
        chk({port_conn, tx_en, rx_en, bias_en, bus_rst_req} == 0, "R8",
            {port_conn, tx_en, rx_en, bias_en}, 0);
        chk(cna_all == 0, "R1", cna_all, 0);
        step();
        bias_det = 0;
        #0.5 chk(cna_all == 1, "R1", cna_all, 1);
        bias_det = 3'b111;
        for (int k = 0; k < 2 * DEB; k++) step();
        chk(port_conn == 0 && bus_rst_req == 0, "R8", {port_conn, bus_rst_req}, 0);
        pd = 0;
        for (int k = 1; k < DEB; k++) step();
        chk(port_conn == 0, "R8", port_conn, 0);
        step();
        chk(port_conn == 3'b111 && bus_rst_req == 3'b111, "R8",
            {port_conn, bus_rst_req}, 6'b111111);
        step();

        // R9 reset clears connected ports
        rst_n = 0;
        step();
        chk(port_conn == 0 && bus_rst_req == 0, "R9", {port_conn, bus_rst_req}, 0);
        rst_n = 1;
        step();
        chk(port_conn == 0, "R9", port_conn, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule